// File: doc/BRIEF.md
# Dual Cascadable 8-bit Reload Timer

This block holds two 8-bit down-counters, called the lower timer (index 0) and the upper timer (index 1). Each counter reloads from its own reload register when it passes zero. Each timer picks its count enable from one of these sources:

- every cycle of the block clock;
- the block clock divided by 8, 32 or 128, taken from one shared free-running prescaler;
- rising edges of a synchronised external event pin;
- the underflow tick of the other timer.

Every underflow gives a one-cycle tick for use by other blocks, for example as the bit-rate clock of a serial channel. It also gives a one-cycle interrupt pulse, which can be masked, and it toggles a square-wave output.

A cascade bit joins the pair into one 16-bit counter. The lower timer's run bit and source drive the pair. The upper byte takes a borrow from the lower byte. Only the end of the 16-bit count raises a tick, an interrupt and a toggle, and that happens on the upper timer. Software sets up the block through a write-only port: a write enable, an address and a data byte.

Register addresses:

- address 0: lower control
- address 1: lower reload
- address 2: upper control
- address 3: upper reload

Control byte fields:

- bits [2:0]: source code
- bit 3: run
- bit 4: interrupt enable
- bit 5: cascade, which has effect only in the upper control

Top module: `tmr_pair8`

## Requirements
- R1: After reset, all underflow ticks, interrupt pulses and square-wave outputs are low.
- R2: Source code 0 counts every clock. The counter steps down from its reload value R, and on the enabled tick at zero it reloads R. A one-cycle underflow tick follows in the next cycle, so ticks come every R+1 clocks.
- R3: Source codes 1, 2 and 3 count on single-cycle enables from a free-running prescaler. The tick periods are 8·(R+1), 32·(R+1) and 128·(R+1) clocks.
- R4: Source code 4 counts rising edges of the timer's event pin after a two-stage synchroniser. The underflow comes on the (R+1)-th rising edge. A pin that stays high or falls does not count.
- R5: Source code 5 counts underflow ticks of the other timer. With the lower timer at period P, the upper timer's period is P·(R+1).
- R6: With the cascade bit set, the pair counts as one 16-bit value {upper reload, lower reload}, and the upper tick comes every that value + 1 clocks. The lower timer gives no tick and no interrupt.
- R7: The square-wave output toggles on every underflow tick and is low while its timer is stopped.
- R8: The interrupt pulse equals the underflow tick when interrupt enable is 1. It stays low when interrupt enable is 0, while the tick goes on.
- R9: While run is 0 the counter holds its reload value and gives no tick.
- R10: A reload written while the timer runs does not change the period in progress. It takes effect at the next underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..3 used) |
| wr_data | input | 8 | Register write data |
| ev_pin | input | 2 | External event pins, one per timer |
| uf_tick | output | 2 | One-cycle underflow ticks |
| uf_irq | output | 2 | Masked one-cycle interrupt pulses |
| pulse_out | output | 2 | Square-wave outputs toggling per underflow |

## Verification
A reload of 0 on the clock source must give a tick on every clock. An off-by-one in the zero detect would give period 2 there, or 257 at reload 255.

In cascade mode the bench checks the full 516-clock period and that the lower timer stays silent. A lower byte that reloaded instead of wrapping to all-ones would give a much shorter period. A lower timer that was not masked would tick every 4 clocks.

Event counting is checked with long pin-high levels, which would add counts if the design counted levels instead of edges. A reload written mid-period must leave the current period unchanged. A design that loaded the counter at write time would cut that period short.

// File: rtl/tmr_pair8_pkg.sv
package tmr_pair8_pkg;

   // count-enable source codes held in control bits [2:0]
   typedef enum logic [2:0] {
      SRC_CLK    = 3'd0,
      SRC_DIV8   = 3'd1,
      SRC_DIV32  = 3'd2,
      SRC_DIV128 = 3'd3,
      SRC_PIN    = 3'd4,
      SRC_SIB    = 3'd5,
      SRC_NONE6  = 3'd6,
      SRC_NONE7  = 3'd7
   } src_e;

   localparam int CTL_SRC_W = 3;
   localparam int CTL_RUN   = 3;
   localparam int CTL_IRQ   = 4;
   localparam int CTL_CASC  = 5;
   localparam int CTL_W     = 6;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PRE_W = 7,
   parameter int SH0   = 3,
   parameter int SH1   = 5,
   parameter int SH2   = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [2:0] tap_o
);

   localparam int NTAP = 3;
   localparam int SHV [NTAP] = '{SH0, SH1, SH2};

   logic [PRE_W-1:0] cnt_q;

   if (!(SH0 >= 1 && SH0 < SH1 && SH1 < SH2 && SH2 <= PRE_W)) begin : g_bad_taps
      $error("tmr_prescale: taps must rise strictly and fit in PRE_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   for (genvar k = 0; k < NTAP; k++) begin : g_tap
      assign tap_o[k] = &cnt_q[SHV[k]-1:0];
   end

   // R3
   div_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o[2] |=> !tap_o[2]);

   // R3
   div_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o[2] |-> (tap_o[1] && tap_o[0]));

endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_pin_sync: at least two synchroniser stages required");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

   // R4
   rise_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             wrap_max,
   input  logic             uf_mask,
   input  logic [CNT_W-1:0] reload,
   output logic             at_zero,
   output logic             uf,
   output logic             pulse
);

   logic [CNT_W-1:0] cnt_q;
   logic             hit;
   logic             fire;

   assign at_zero = (cnt_q == '0);
   assign hit     = run & tick & at_zero;
   assign fire    = hit & ~wrap_max & ~uf_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         uf    <= 1'b0;
         pulse <= 1'b0;
      end else if (!run) begin
         cnt_q <= reload;
         uf    <= 1'b0;
         pulse <= 1'b0;
      end else begin
         uf <= fire;
         if (fire) pulse <= ~pulse;
         if (tick) begin
            if (!at_zero)      cnt_q <= cnt_q - 1'b1;
            else if (wrap_max) cnt_q <= '1;
            else               cnt_q <= reload;
         end
      end
   end

   // R2
   reload_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf |-> (cnt_q == $past(reload)));

   // R9
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!uf && !pulse));

   // R7
   pulse_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf |-> (pulse != $past(pulse)));

   // R7
   pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !uf) |-> $stable(pulse));

endmodule

// File: rtl/tmr_pair8.sv
module tmr_pair8
   import tmr_pair8_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int ADDR_W      = 3,
   parameter int PRE_W       = 7,
   parameter int DIV_SH0     = 3,
   parameter int DIV_SH1     = 5,
   parameter int DIV_SH2     = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [1:0]        ev_pin,
   output logic [1:0]        uf_tick,
   output logic [1:0]        uf_irq,
   output logic [1:0]        pulse_out
);

   localparam int NTMR = 2;

   if (CNT_W < CTL_W) begin : g_bad_width
      $error("tmr_pair8: data width too narrow for the control fields");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("tmr_pair8: address must reach four registers");
   end

   src_e             src_q  [NTMR];
   logic [CNT_W-1:0] rel_q  [NTMR];
   logic [NTMR-1:0]  run_q;
   logic [NTMR-1:0]  irq_q;
   logic             casc_q;

   logic [2:0]       pre_tap;
   logic [NTMR-1:0]  pin_rise;
   logic [NTMR-1:0]  sel_tick;
   logic [NTMR-1:0]  zero_v;
   logic [NTMR-1:0]  uf_v;
   logic [NTMR-1:0]  pulse_v;
   logic [NTMR-1:0]  run_v;
   logic [NTMR-1:0]  tick_v;
   logic [NTMR-1:0]  wrap_v;
   logic [NTMR-1:0]  mask_v;
   logic             lo_borrow;

   function automatic logic pick_src(input src_e s, input logic [2:0] taps,
                                     input logic rise, input logic sib);
      case (s)
         SRC_CLK:    return 1'b1;
         SRC_DIV8:   return taps[0];
         SRC_DIV32:  return taps[1];
         SRC_DIV128: return taps[2];
         SRC_PIN:    return rise;
         SRC_SIB:    return sib;
         default:    return 1'b0;
      endcase
   endfunction

   // register writes: even address = control, odd = reload
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NTMR; i++) begin
            src_q[i] <= SRC_CLK;
            rel_q[i] <= '0;
         end
         run_q  <= '0;
         irq_q  <= '0;
         casc_q <= 1'b0;
      end else if (wr_en) begin
         for (int i = 0; i < NTMR; i++) begin
            if (wr_addr == ADDR_W'(2 * i)) begin
               src_q[i] <= src_e'(wr_data[CTL_SRC_W-1:0]);
               run_q[i] <= wr_data[CTL_RUN];
               irq_q[i] <= wr_data[CTL_IRQ];
               if (i == NTMR - 1) casc_q <= wr_data[CTL_CASC];
            end
            if (wr_addr == ADDR_W'(2 * i + 1)) rel_q[i] <= wr_data;
         end
      end
   end

   tmr_prescale #(
      .PRE_W (PRE_W),
      .SH0   (DIV_SH0),
      .SH1   (DIV_SH1),
      .SH2   (DIV_SH2)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tap_o (pre_tap)
   );

   // cascade routing: upper byte borrows from lower byte
   assign lo_borrow = run_q[0] & sel_tick[0] & zero_v[0];

   always_comb begin
      run_v[0]  = run_q[0];
      tick_v[0] = sel_tick[0];
      wrap_v[0] = casc_q & ~zero_v[1];
      mask_v[0] = casc_q;
      run_v[1]  = casc_q ? run_q[0] : run_q[1];
      tick_v[1] = casc_q ? lo_borrow : sel_tick[1];
      wrap_v[1] = 1'b0;
      mask_v[1] = 1'b0;
   end

   for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
      tmr_pin_sync #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (ev_pin[gi]),
         .rise_o (pin_rise[gi])
      );

      assign sel_tick[gi] = pick_src(src_q[gi], pre_tap, pin_rise[gi],
                                     uf_v[NTMR-1-gi]);

      tmr_chan #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run_v[gi]),
         .tick     (tick_v[gi]),
         .wrap_max (wrap_v[gi]),
         .uf_mask  (mask_v[gi]),
         .reload   (rel_q[gi]),
         .at_zero  (zero_v[gi]),
         .uf       (uf_v[gi]),
         .pulse    (pulse_v[gi])
      );
   end

   assign uf_tick   = uf_v;
   assign uf_irq    = uf_v & irq_q;
   assign pulse_out = pulse_v;

   // R6
   casc_lower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (casc_q && $past(casc_q)) |-> (!uf_tick[0] && !uf_irq[0]));

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) == 1'b0 && !irq_q[0]) |-> !uf_irq[0]);

endmodule

// File: tb/tmr_pair8_bench.sv
module tmr_pair8_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 7;
   // {source code, reload, expected tick period in clocks}
   localparam logic [26:0] VEC [NVEC] = '{
      {3'd0, 8'd5,   16'd6},
      {3'd0, 8'd0,   16'd1},
      {3'd0, 8'd255, 16'd256},
      {3'd1, 8'd2,   16'd24},
      {3'd1, 8'd0,   16'd8},
      {3'd2, 8'd1,   16'd64},
      {3'd3, 8'd0,   16'd128}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] ev_pin = '0;
   logic [1:0] uf_tick;
   logic [1:0] uf_irq;
   logic [1:0] pulse_out;

   int total = 0;
   int fails = 0;
   bit done = 0;
   logic clr = 1'b0;
   int tk0 = 0, tk1 = 0, iq0 = 0, iq1 = 0;

   tmr_pair8 u_tmr_pair8 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .ev_pin    (ev_pin),
      .uf_tick   (uf_tick),
      .uf_irq    (uf_irq),
      .pulse_out (pulse_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (clr) begin
         tk0 <= 0; tk1 <= 0; iq0 <= 0; iq1 <= 0;
      end else begin
         tk0 <= tk0 + int'(uf_tick[0]);
         tk1 <= tk1 + int'(uf_tick[1]);
         iq0 <= iq0 + int'(uf_irq[0]);
         iq1 <= iq1 + int'(uf_irq[1]);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_counts();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic stop_all();
      wr(3'd2, 8'd0);
      wr(3'd0, 8'd0);
      cycles(3);
   endtask

   task automatic measure(input int idx, output int per);
      int guard = 0;
      per = -1;
      while (!uf_tick[idx] && guard < 3000) begin
         @(negedge clk); guard++;
      end
      if (guard >= 3000) return;
      per = 0;
      do begin
         @(negedge clk); per++;
      end while (!uf_tick[idx] && per < 3000);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      int per, p0, p1, pm;
      cycles(5);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 outputs after reset", {uf_tick, uf_irq, pulse_out}, 0);

      // R2 / R3 vector table on the lower timer
      for (int v = 0; v < NVEC; v++) begin
         wr(3'd1, VEC[v][23:16]);
         wr(3'd0, {5'b00011, VEC[v][26:24]});
         measure(0, per);
         check(VEC[v][26:24] == 3'd0 ? "R2 clock-source period" : "R3 prescaled period",
               per, int'(VEC[v][15:0]));
         stop_all();
      end

      // R7 square wave: toggles at each tick, steady in between
      wr(3'd1, 8'd4);
      wr(3'd0, 8'h08);
      measure(0, per);
      p0 = pulse_out[0];
      cycles(2);
      pm = pulse_out[0];
      cycles(3);
      p1 = pulse_out[0];
      check("R7 pulse steady between ticks", pm, p0);
      check("R7 pulse toggled at tick", p1, 1 - p0);
      stop_all();

      // R8 interrupt gating
      wr(3'd1, 8'd2);
      wr(3'd0, 8'h08);
      cycles(4);
      clear_counts();
      cycles(30);
      check("R8 tick runs with irq off", tk0, 10);
      check("R8 irq low with irq off", iq0, 0);
      wr(3'd0, 8'h18);
      clear_counts();
      cycles(30);
      check("R8 irq follows tick when enabled", iq0, 10);

      // R9 stopped timer is quiet
      wr(3'd0, 8'h10);
      cycles(2);
      clear_counts();
      cycles(50);
      check("R9 no tick while stopped", tk0, 0);
      check("R9 pulse low while stopped", pulse_out[0], 0);
      stop_all();

      // R4 event pin counting
      wr(3'd1, 8'd2);
      wr(3'd0, 8'h0C);
      cycles(2);
      clear_counts();
      for (int e = 0; e < 2; e++) begin
         ev_pin[0] = 1'b1; cycles(8);
         ev_pin[0] = 1'b0; cycles(4);
      end
      cycles(4);
      check("R4 no tick after two edges", tk0, 0);
      ev_pin[0] = 1'b1; cycles(8);
      check("R4 tick on third edge", tk0, 1);
      ev_pin[0] = 1'b0;
      stop_all();

      // R5 sibling source
      wr(3'd1, 8'd1);
      wr(3'd3, 8'd2);
      wr(3'd2, 8'h0D);
      wr(3'd0, 8'h08);
      measure(1, per);
      measure(1, per);
      check("R5 upper counts lower ticks", per, 6);
      stop_all();

      // R6 cascade as one 16-bit counter
      wr(3'd1, 8'd3);
      wr(3'd3, 8'd2);
      wr(3'd2, 8'h30);
      wr(3'd0, 8'h18);
      measure(1, per);
      check("R6 cascade 16-bit period", per, 516);
      clear_counts();
      cycles(600);
      check("R6 lower tick silent in cascade", tk0, 0);
      check("R6 lower irq silent in cascade", iq0, 0);
      check("R6 upper irq raised in cascade", iq1 > 0, 1);
      stop_all();

      // R10 reload written mid-period
      wr(3'd1, 8'd9);
      wr(3'd0, 8'h08);
      per = 0;
      measure(0, per);
      wr(3'd1, 8'd3);
      per = 1;
      while (!uf_tick[0] && per < 100) begin
         @(negedge clk); per++;
      end
      check("R10 current period kept", per, 10);
      measure(0, per);
      check("R10 new reload at next period", per, 4);
      stop_all();

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule